// File: doc/BRIEF.md
# Compute Zero Index Unit

This block locates the first element of a 64-bit operand whose bits are all zero. The operand is split into eight byte elements or four 16-bit elements, and the search runs from the most significant end or from the least significant end. The result is the element's position in the scan order. When no element is zero, the result is one past the last valid position.

An operand is presented with its element-size and direction selects under a valid/ready handshake. One clock after the input is accepted, the result appears on a 64-bit output with a one-cycle valid flag. Every candidate element is tested in parallel. A priority choice then picks the earliest hit in scan order. The result register holds its value between accepted inputs.

Top module: `czi_top`

## Requirements
- R1: With inHalfMode=0 the operand is eight byte elements. Element e occupies bits [8e+7:8e]. With inHalfMode=1 it is four 16-bit elements, and element e occupies bits [16e+15:16e].
- R2: The result is the scan-order position of the first element whose bits are all zero. When several elements are zero, only the earliest one in scan order determines the result.
- R3: When no element is zero, the result is 8 in byte mode and 4 in 16-bit mode.
- R4: With inScanRight=0 the most significant element has position 0, and positions increase toward the least significant end.
- R5: With inScanRight=1 the least significant element has position 0, and positions increase toward the most significant end.
- R6: The result is 4 bits wide, and outIndex[63:4] is always zero.
- R7: inReady is high outside reset. outValid is high in exactly the cycle after an accepted input (inValid and inReady both high at a clock edge), and low otherwise.
- R8: A synchronous reset clears outValid and outIndex to zero.
- R9: The size and direction selects are sampled only together with the operand. Changing any input while inValid is low leaves outIndex unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand valid |
| inReady | output | 1 | Unit can accept an operand |
| inOperand | input | 64 | Operand to search |
| inHalfMode | input | 1 | 0: byte elements, 1: 16-bit elements |
| inScanRight | input | 1 | 0: scan from the most significant end, 1: scan from the least significant end |
| outValid | output | 1 | Result valid, one cycle |
| outIndex | output | 64 | Zero-extended result position |

## Verification
In a single cycle the unit can present the result of one operand while it accepts the next. This means the capture of a new result and the presentation of the previous one overlap. The bench provokes this by driving operands on back-to-back cycles with alternating size and direction selects. Each result must match its own operand's settings, and outValid must not drop between them. The priority choice and the no-zero case are also driven in the same stream, so that a stale or mixed-up setting would show up as a wrong index.

// File: rtl/czi_pkg.sv
package czi_pkg;
  parameter int DATA_W = 64;
  parameter int BYTE_W = 8;
  parameter int HALF_W = 16;
  parameter int IDX_W  = 4;
  localparam int N_BYTE = DATA_W / BYTE_W;
  localparam int N_HALF = DATA_W / HALF_W;

  typedef struct packed {
    logic capture;
    logic clear;
  } czi_strobe_t;
endpackage

// File: rtl/czi_ctrl.sv
module czi_ctrl
  import czi_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  output czi_strobe_t strobe
);
  logic validReg;

  assign inReady        = !rst;
  assign strobe.capture = inValid && inReady;
  assign strobe.clear   = rst;

  always_ff @(posedge clk) begin
    if (rst) validReg <= 1'b0;
    else     validReg <= strobe.capture;
  end

  assign outValid = validReg;
endmodule

// File: rtl/czi_datapath.sv
module czi_datapath
  import czi_pkg::*;
(
  input  logic              clk,
  input  czi_strobe_t       strobe,
  input  logic [DATA_W-1:0] operand,
  input  logic              halfMode,
  input  logic              scanRight,
  output logic [DATA_W-1:0] index
);
  localparam logic [IDX_W-1:0] BYTE_NONE = IDX_W'(N_BYTE);
  localparam logic [IDX_W-1:0] HALF_NONE = IDX_W'(N_HALF);

  logic [N_BYTE-1:0] byteZero;
  logic [N_HALF-1:0] halfZero;
  logic [IDX_W-1:0]  byteLeft, byteRight, halfLeft, halfRight, nextIdx, idxReg;

  for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
    assign byteZero[b] = ~|operand[b*BYTE_W +: BYTE_W];
  end
  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign halfZero[h] = ~|operand[h*HALF_W +: HALF_W];
  end

  always_comb begin
    byteLeft  = BYTE_NONE;
    byteRight = BYTE_NONE;
    for (int k = N_BYTE - 1; k >= 0; k--) begin
      if (byteZero[N_BYTE-1-k]) byteLeft  = IDX_W'(k);
      if (byteZero[k])          byteRight = IDX_W'(k);
    end
  end

  always_comb begin
    halfLeft  = HALF_NONE;
    halfRight = HALF_NONE;
    for (int k = N_HALF - 1; k >= 0; k--) begin
      if (halfZero[N_HALF-1-k]) halfLeft  = IDX_W'(k);
      if (halfZero[k])          halfRight = IDX_W'(k);
    end
  end

  always_comb begin
    unique case ({halfMode, scanRight})
      2'b00:   nextIdx = byteLeft;
      2'b01:   nextIdx = byteRight;
      2'b10:   nextIdx = halfLeft;
      default: nextIdx = halfRight;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)        idxReg <= '0;
    else if (strobe.capture) idxReg <= nextIdx;
  end

  assign index = {{(DATA_W-IDX_W){1'b0}}, idxReg};
endmodule

// File: rtl/czi_top.sv
module czi_top
  import czi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inOperand,
  input  logic              inHalfMode,
  input  logic              inScanRight,
  output logic              outValid,
  output logic [DATA_W-1:0] outIndex
);
  czi_strobe_t strobe;

  czi_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  czi_datapath u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .operand   (inOperand),
    .halfMode  (inHalfMode),
    .scanRight (inScanRight),
    .index     (outIndex)
  );
endmodule

// File: rtl/czi_checker.sv
module czi_checker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        inReady,
  input logic [63:0] inOperand,
  input logic        inHalfMode,
  input logic        inScanRight,
  input logic        outValid,
  input logic [63:0] outIndex
);
  logic accepted;
  assign accepted = inValid && inReady;

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accepted |=> outValid); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> !outValid); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!outValid && outIndex == 64'd0)); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    outIndex[63:4] == 60'd0); // R6
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (accepted && (&inOperand)) |=> outIndex == (($past(inHalfMode)) ? 64'd4 : 64'd8)); // R3
  AST_LEFT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (accepted && !inScanRight && !inHalfMode && inOperand[63:56] == 8'd0) |=> outIndex == 64'd0); // R4
  AST_RIGHT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (accepted && inScanRight && inHalfMode && inOperand[15:0] == 16'd0) |=> outIndex == 64'd0); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> $stable(outIndex)); // R9
endmodule

bind czi_top czi_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .inValid     (inValid),
  .inReady     (inReady),
  .inOperand   (inOperand),
  .inHalfMode  (inHalfMode),
  .inScanRight (inScanRight),
  .outValid    (outValid),
  .outIndex    (outIndex)
);

// File: tb/tb_czi_top.sv
`timescale 1ns/1ps
module tb_czi_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic        inReady;
  logic [63:0] inOperand;
  logic        inHalfMode;
  logic        inScanRight;
  logic        outValid;
  logic [63:0] outIndex;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  czi_top dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inOperand(inOperand), .inHalfMode(inHalfMode), .inScanRight(inScanRight),
    .outValid(outValid), .outIndex(outIndex)
  );

  function automatic logic [63:0] model(input logic [63:0] op, input logic half, input logic right);
    int n = half ? 4 : 8;
    int w = half ? 16 : 8;
    logic [63:0] mask = half ? 64'hFFFF : 64'hFF;
    int res = n;
    for (int k = n - 1; k >= 0; k--) begin
      int e = right ? k : n - 1 - k;
      if (((op >> (e * w)) & mask) == 64'd0) res = k;
    end
    return 64'(res);
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one operand at a negedge, check the result one cycle later
  task automatic apply(input string req, input logic [63:0] op, input logic half, input logic right);
    inOperand = op; inHalfMode = half; inScanRight = right; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, {63'd0, outValid}, 64'd1);
    check(req, outIndex, model(op, half, right));
  endtask

  task automatic t_reset;
    rst = 1'b1; inValid = 1'b0; inOperand = '0; inHalfMode = 1'b0; inScanRight = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset valid", {63'd0, outValid}, 64'd0);
    check("R8 reset index", outIndex, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 ready", {63'd0, inReady}, 64'd1);
  endtask

  task automatic t_byte;
    apply("R4 R1 byte left msb", 64'h00FF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    apply("R4 R2 byte left pos1", 64'h1100_2233_0044_5566, 1'b0, 1'b0);
    apply("R5 R2 byte right pos3", 64'h1100_2233_0044_5566, 1'b0, 1'b1);
    apply("R5 byte right lsb", 64'hFFFF_FFFF_FFFF_FF00, 1'b0, 1'b1);
    apply("R2 byte many zeros left", 64'h0100_0000_0000_0000, 1'b0, 1'b0);
    apply("R4 byte left last", 64'h0101_0101_0101_0100, 1'b0, 1'b0);
  endtask

  task automatic t_half;
    apply("R1 half none zero", 64'h1100_2233_0044_5566, 1'b1, 1'b0);
    apply("R4 half left pos2", 64'h1234_5678_0000_9ABC, 1'b1, 1'b0);
    apply("R5 half right pos1", 64'h1234_5678_0000_9ABC, 1'b1, 1'b1);
    apply("R2 half many zeros right", 64'h0000_0000_0001_0000, 1'b1, 1'b1);
  endtask

  task automatic t_none;
    apply("R3 byte none", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    apply("R3 half none right", 64'h0101_0101_0101_0101, 1'b1, 1'b1);
    check("R6 upper bits", {4'd0, outIndex[63:4]}, 64'd0);
    apply("R3 byte none right", 64'h8080_8080_8080_8080, 1'b0, 1'b1);
  endtask

  task automatic t_onecycle;
    apply("R7 pulse", 64'h1100_0000_0000_0000, 1'b0, 1'b1);
    @(negedge clk);
    check("R7 valid drops", {63'd0, outValid}, 64'd0);
  endtask

  task automatic t_idle_change;
    apply("R9 base", 64'hFF00_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    inOperand = 64'h0; inHalfMode = 1'b1; inScanRight = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 idle hold", outIndex, 64'd1);
    check("R9 idle no valid", {63'd0, outValid}, 64'd0);
  endtask

  task automatic t_back_to_back;
    logic [63:0] ops [4] = '{64'h0000_1111_2222_3333, 64'h1111_2222_3333_0000,
                              64'hAA00_BB00_CC00_DDEE, 64'hFFFF_FFFF_FFFF_FFFF};
    logic [63:0] prevExp;
    for (int i = 0; i < 4; i++) begin
      inOperand = ops[i]; inHalfMode = i[0]; inScanRight = i[1]; inValid = 1'b1;
      prevExp = model(ops[i], i[0], i[1]);
      @(negedge clk);
      check("R7 back-to-back valid", {63'd0, outValid}, 64'd1);
      check("R2 back-to-back index", outIndex, prevExp);
    end
    inValid = 1'b0;
    @(negedge clk);
    check("R7 stream end", {63'd0, outValid}, 64'd0);
  endtask

  task automatic t_mid_reset;
    inOperand = 64'h0; inHalfMode = 1'b0; inScanRight = 1'b0; inValid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R8 reset beats accept valid", {63'd0, outValid}, 64'd0);
    check("R8 reset beats accept index", outIndex, 64'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_byte();
    t_half();
    t_none();
    t_onecycle();
    t_idle_change();
    t_back_to_back();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule